// File: doc/BRIEF.md
# Bit-serial complex multiplier by a constant signed-digit coefficient

This block multiplies a stream of complex samples by one fixed complex coefficient, as a butterfly stage of a fast transform needs for its twiddle factors. The real and imaginary parts of the coefficient are build-time parameters. Each is written in canonic signed-digit form, as a mask of +1 digits and a mask of -1 digits. The two parts of each sample arrive side by side, one bit per clock, as two's complement words sent least significant bit first. The block returns the real part Ar·Xr − Ai·Xi and the imaginary part Ar·Xi + Ai·Xr on two serial outputs, also least significant bit first and in the same cycles.

Two adder rows do the work of four multipliers, one row for each output. Each digit position of a row holds no full adder, one full adder or two cascaded full adders, according to how many of the two coefficient digits at that position are non-zero. An operand bit is inverted when its digit calls for it. The sign bit gets the opposite inversion, so no sign extension is needed. The carries are preset at the start of a word, and a fixed high-order correction enters serially at the free sum input of the top cell.

A frame lasts 2·N clocks: N data bits, then N ignored gap bits, so the block runs at half rate. The product is W = 2·N bits wide.

Top module: `cplx_csd_smul`

## Requirements
- R1: Over the W = 2·N output cycles of a frame, `mr_bit` carries (Ar·Xr − Ai·Xi) mod 2^W, least significant bit first, where Xr and Xi are the N-bit two's complement operands.
- R2: Over the same cycles, `mi_bit` carries (Ar·Xi + Ai·Xr) mod 2^W, least significant bit first.
- R3: `word_start` is high in the cycle of operand bit 0, and bits 0..N-1 of both operands follow in consecutive cycles. Product bit t appears on both outputs t+1 cycles after the start cycle. `prod_lsb` is high only in the cycle that carries product bit 0.
- R4: Operand bits presented in frame cycles N..2N-1 have no effect on the results.
- R5: The results are exact for the extreme operands −2^(N-1) and 2^(N-1)−1 in every combination.
- R6: Frames may follow each other with no idle cycle (a new `word_start` every 2·N cycles). No sum or carry state passes from one frame into the next.
- R7: After reset, `prod_lsb`, `mr_bit` and `mi_bit` are 0. `prod_lsb` stays 0 in any cycle that does not follow a `word_start` cycle.
- R8: The results are exact for any coefficient pair in canonic signed-digit form with M_DIG ≤ N_BITS − 1 digits. This covers positions where both parts have a non-zero digit, positions where only one does, and positions where neither does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| word_start | input | 1 | High in the cycle of operand bit 0 |
| xr_bit | input | 1 | Real part of the sample, serial, LSB first |
| xi_bit | input | 1 | Imaginary part of the sample, serial, LSB first |
| mr_bit | output | 1 | Real part of the product, serial, LSB first |
| mi_bit | output | 1 | Imaginary part of the product, serial, LSB first |
| prod_lsb | output | 1 | High when the outputs carry product bit 0 |

## Verification
A unit real operand with a zero imaginary operand, and then the reverse, gives Ar and Ai on the outputs. This shows whether each row takes the right operand, with the right sign, at each digit. The four extreme operand pairs exercise the sign-bit inversion and the high-order correction, where an error shows up only in the upper product bits. The same word is sent once with a quiet gap and once with random gap bits, to separate gating faults from arithmetic faults. Random words sent back to back, through two instances (one with two-adder positions, one with only single-adder positions), catch carry or sum state that leaks across frame boundaries.

// File: rtl/csdcm_pkg.sv
// Shared types and constant helpers for the serial complex constant multiplier.
// Assumes coefficient masks fit in 32 bits and the product fits in 64 bits.
package csdcm_pkg;

    // Number of full adders a digit position of one row holds.
    typedef enum logic [1:0] {
        CK_EMPTY  = 2'd0,
        CK_SINGLE = 2'd1,
        CK_DOUBLE = 2'd2
    } cell_kind_e;

    // One-bit full adder, returns {carry, sum}.
    function automatic logic [1:0] fa(input logic a, input logic b, input logic c);
        return {(a & b) | (a & c) | (b & c), a ^ b ^ c};
    endfunction

    // High-order correction: every non-zero digit at weight 2^k adds
    // -2^(k+n-1). It is the same for both rows, since each row holds one
    // term per non-zero digit of either coefficient part.
    function automatic logic [63:0] hi_const(input logic [31:0] ar_nz,
                                             input logic [31:0] ai_nz,
                                             input int n_bits);
        logic [63:0] s;
        s = 64'(ar_nz) + 64'(ai_nz);
        return 64'd0 - (s << (n_bits - 1));
    endfunction

endpackage

// File: rtl/csdcm_ctrl.sv
// Frame sequencer. Follows the position of the current operand bit inside a
// frame of W cycles that starts with word_start. Gives the first-bit
// marker, the data window (bits 0..N-1) and the sign-bit marker.
// Assumes W > N. Waits idle (index W) until the first word_start.
module csdcm_ctrl #(
    parameter int N  = 10,
    parameter int W  = 20,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          first,
    output logic          in_data,
    output logic          msb,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] ph_q;

    // Current bit index: zero on a start, otherwise the running phase.
    always_comb begin
        idx     = start ? '0 : ph_q;
        first   = start;
        in_data = (idx < IW'(N));
        msb     = (idx == IW'(N - 1));
    end

    // Phase register: advances once per cycle and stops at W (idle).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= IW'(W);
        end else if (idx < IW'(W)) begin
            ph_q <= idx + IW'(1);
        end else begin
            ph_q <= IW'(W);
        end
    end
endmodule

// File: rtl/csdcm_cell.sv
// One digit position of an adder row. KIND picks 0, 1 or 2 full adders.
// term_a and term_b are partial product bits, already inverted and gated.
// On the first cycle of a word the incoming sum is taken as zero and each
// carry loads its preset (1 for a negative term, the low correction).
module csdcm_cell #(
    parameter csdcm_pkg::cell_kind_e KIND = csdcm_pkg::CK_EMPTY,
    parameter bit PRE_A = 1'b0,
    parameter bit PRE_B = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic first,
    input  logic term_a,
    input  logic term_b,
    input  logic s_in,
    output logic s_q
);
    logic s_eff;

    // Sum from the left neighbour, cleared on the first bit of a word.
    assign s_eff = first ? 1'b0 : s_in;

    if (KIND == csdcm_pkg::CK_DOUBLE) begin : g_dbl
        logic ca_q, cb_q, ca_in, cb_in, ca_d, cb_d, s_mid, s_d;

        // Two cascaded adders: first term, then second term.
        always_comb begin
            ca_in        = first ? PRE_A : ca_q;
            cb_in        = first ? PRE_B : cb_q;
            {ca_d, s_mid} = csdcm_pkg::fa(term_a, s_eff, ca_in);
            {cb_d, s_d}   = csdcm_pkg::fa(term_b, s_mid, cb_in);
        end

        // Sum and both carry delay elements.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_q <= 1'b0; ca_q <= 1'b0; cb_q <= 1'b0;
            end else begin
                s_q <= s_d; ca_q <= ca_d; cb_q <= cb_d;
            end
        end
    end else if (KIND == csdcm_pkg::CK_SINGLE) begin : g_sgl
        logic ca_q, ca_in, ca_d, s_d;
        logic unused_tb;
        assign unused_tb = term_b;

        // Single adder on the one active term.
        always_comb begin
            ca_in      = first ? PRE_A : ca_q;
            {ca_d, s_d} = csdcm_pkg::fa(term_a, s_eff, ca_in);
        end

        // Sum and carry delay elements.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_q <= 1'b0; ca_q <= 1'b0;
            end else begin
                s_q <= s_d; ca_q <= ca_d;
            end
        end
    end else begin : g_empty
        logic unused_terms;
        assign unused_terms = term_a | term_b;

        // Empty position: the sum only passes through a delay element.
        always_ff @(posedge clk) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= s_eff;
        end
    end
endmodule

// File: rtl/csdcm_row.sv
// One serial/parallel adder row. Position k adds the digit-weighted real
// operand (masks XR_*) and imaginary operand (masks XI_*). Sums move from
// position M-1 down to 0, and position 0 gives one product bit per cycle.
// inj feeds the free sum input of the top position. A term bit is inverted
// for a negative digit, and inverted the opposite way on the sign bit.
module csdcm_row #(
    parameter int M = 8,
    parameter logic [M-1:0] XR_POS = '0,
    parameter logic [M-1:0] XR_NEG = '0,
    parameter logic [M-1:0] XI_POS = '0,
    parameter logic [M-1:0] XI_NEG = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic first,
    input  logic in_data,
    input  logic msb,
    input  logic xr,
    input  logic xi,
    input  logic inj,
    output logic prod_bit
);
    import csdcm_pkg::*;

    logic [M-1:0] sq;

    for (genvar k = 0; k < M; k++) begin : g_pos
        localparam bit UR = XR_POS[k] | XR_NEG[k];
        localparam bit UI = XI_POS[k] | XI_NEG[k];
        localparam cell_kind_e KD = (UR && UI) ? CK_DOUBLE :
                                    ((UR || UI) ? CK_SINGLE : CK_EMPTY);
        localparam bit PA = UR ? XR_NEG[k] : XI_NEG[k];
        localparam bit PB = XI_NEG[k];
        logic ta, tb, sin;

        // Route the active terms: real operand first, then imaginary.
        assign ta = UR ? (in_data & (xr ^ (XR_NEG[k] ^ msb))) :
                    (UI ? (in_data & (xi ^ (XI_NEG[k] ^ msb))) : 1'b0);
        assign tb = (UR && UI) ? (in_data & (xi ^ (XI_NEG[k] ^ msb))) : 1'b0;

        if (k == M - 1) begin : g_top
            assign sin = inj;
        end else begin : g_mid
            assign sin = sq[k + 1];
        end

        csdcm_cell #(.KIND(KD), .PRE_A(PA), .PRE_B(PB)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .first  (first),
            .term_a (ta),
            .term_b (tb),
            .s_in   (sin),
            .s_q    (sq[k])
        );
    end

    assign prod_bit = sq[0];
endmodule

// File: rtl/cplx_csd_smul.sv
// Bit-serial product of a streaming complex sample and a constant complex
// coefficient in canonic signed-digit form. The upper row gives the
// imaginary part, the lower row the real part. Frame: W = 2*N cycles with
// N data bits, LSB first. Product bit t leaves t+1 cycles after word_start.
// Assumes: masks with no position both +1 and -1, no two adjacent
// non-zero digits, and M_DIG <= N_BITS-1 so that the product fits W bits.
module cplx_csd_smul #(
    parameter int N_BITS = 10,
    parameter int M_DIG  = 8,
    parameter logic [M_DIG-1:0] AR_POS = 8'h80,
    parameter logic [M_DIG-1:0] AR_NEG = 8'h25,
    parameter logic [M_DIG-1:0] AI_POS = 8'h25,
    parameter logic [M_DIG-1:0] AI_NEG = 8'h80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_start,
    input  logic xr_bit,
    input  logic xi_bit,
    output logic mr_bit,
    output logic mi_bit,
    output logic prod_lsb
);
    localparam int W  = 2 * N_BITS;
    localparam int IW = $clog2(W + 1);
    localparam logic [63:0] K_FULL =
        csdcm_pkg::hi_const(32'(AR_POS | AR_NEG), 32'(AI_POS | AI_NEG), N_BITS);
    localparam logic [W-1:0] K_COR = K_FULL[W-1:0];

    logic          first, in_data, msb, kbit;
    logic [IW-1:0] idx;

    csdcm_ctrl #(.N(N_BITS), .W(W), .IW(IW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (word_start),
        .first   (first),
        .in_data (in_data),
        .msb     (msb),
        .idx     (idx)
    );

    // Correction bit for the top sum input, weight 2^(idx+M_DIG-1).
    assign kbit = |(K_COR & (W'(1) << (int'(idx) + M_DIG - 1)));

    // Imaginary row: Ai on the real operand, Ar on the imaginary operand.
    csdcm_row #(.M(M_DIG), .XR_POS(AI_POS), .XR_NEG(AI_NEG),
                .XI_POS(AR_POS), .XI_NEG(AR_NEG)) u_row_im (
        .clk (clk), .rst_n (rst_n), .first (first), .in_data (in_data),
        .msb (msb), .xr (xr_bit), .xi (xi_bit), .inj (kbit),
        .prod_bit (mi_bit)
    );

    // Real row: Ar on the real operand, -Ai on the imaginary operand.
    csdcm_row #(.M(M_DIG), .XR_POS(AR_POS), .XR_NEG(AR_NEG),
                .XI_POS(AI_NEG), .XI_NEG(AI_POS)) u_row_re (
        .clk (clk), .rst_n (rst_n), .first (first), .in_data (in_data),
        .msb (msb), .xr (xr_bit), .xi (xi_bit), .inj (kbit),
        .prod_bit (mr_bit)
    );

    // Bit-0 marker, aligned with the registered row outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) prod_lsb <= 1'b0;
        else        prod_lsb <= first;
    end
endmodule

// File: rtl/csdcm_chk.sv
// Protocol checker for cplx_csd_smul, attached with bind. It keeps its own
// count of cycles since the last word_start and checks the frame flags
// against it.
module csdcm_chk #(
    parameter int N = 10,
    parameter int W = 20
) (
    input logic clk,
    input logic rst_n,
    input logic word_start,
    input logic prod_lsb,
    input logic in_data,
    input logic msb
);
    int since;

    // Cycles since the last word_start, saturating at W.
    always_ff @(posedge clk) begin
        if (!rst_n)          since <= W;
        else if (word_start) since <= 1;
        else if (since < W)  since <= since + 1;
    end

    // R3
    start_flags_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_start |=> prod_lsb);

    // R7
    lsb_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since > 1) |-> !prod_lsb);

    // R4
    gap_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_start && since >= N) |-> !in_data);

    // R3
    data_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start || since < N) |-> in_data);

    // R3
    sign_bit_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msb && !word_start) |-> (since == N - 1));
endmodule

bind cplx_csd_smul csdcm_chk #(.N(N_BITS), .W(2 * N_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_start (word_start),
    .prod_lsb   (prod_lsb),
    .in_data    (in_data),
    .msb        (msb)
);

// File: tb/sim_cplx_csd_smul.sv
// Scoreboard bench: the driver pushes expected products, the monitor
// gathers serial results and compares them. u0: Ar=91, Ai=-91 (two-adder
// positions); u1: Ar=118, Ai=-49 (single-adder positions only).
module sim_cplx_csd_smul;
    localparam int N = 10;
    localparam int M = 8;
    localparam int W = 2 * N;
    localparam int AR0 = 91,  AI0 = -91;
    localparam int AR1 = 118, AI1 = -49;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, xr = 1'b0, xi = 1'b0;
    logic mr0, mi0, lsb0, mr1, mi1, lsb1;
    int   checks = 0, fails = 0;
    bit   done = 1'b0;

    logic [W-1:0] q_r0[$], q_i0[$], q_r1[$], q_i1[$];
    string        q_tag[$];

    always #5 clk = ~clk;

    cplx_csd_smul #(.N_BITS(N), .M_DIG(M)) u0 (
        .clk (clk), .rst_n (rst_n), .word_start (start), .xr_bit (xr),
        .xi_bit (xi), .mr_bit (mr0), .mi_bit (mi0), .prod_lsb (lsb0));

    cplx_csd_smul #(.N_BITS(N), .M_DIG(M), .AR_POS(8'h80), .AR_NEG(8'h0A),
                    .AI_POS(8'h10), .AI_NEG(8'h41)) u1 (
        .clk (clk), .rst_n (rst_n), .word_start (start), .xr_bit (xr),
        .xi_bit (xi), .mr_bit (mr1), .mi_bit (mi1), .prod_lsb (lsb1));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: one frame, N data bits then N gap bits (random if junk).
    task automatic send(input int a, input int b, input bit junk, input string tag);
        logic [N-1:0] va, vb;
        va = N'(a);
        vb = N'(b);
        q_r0.push_back(W'(AR0 * a - AI0 * b));
        q_i0.push_back(W'(AR0 * b + AI0 * a));
        q_r1.push_back(W'(AR1 * a - AI1 * b));
        q_i1.push_back(W'(AR1 * b + AI1 * a));
        q_tag.push_back(tag);
        for (int t = 0; t < W; t++) begin
            @(negedge clk);
            start = (t == 0);
            if (t < N) begin
                xr = va[t];
                xi = vb[t];
            end else begin
                xr = junk ? 1'($urandom) : 1'b0;
                xi = junk ? 1'($urandom) : 1'b0;
            end
        end
    endtask

    // Monitor: collect W result bits after each bit-0 marker.
    int           mcnt = 0;
    bit           extra_lsb = 1'b0;
    logic [W-1:0] cr0, ci0, cr1, ci1;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mcnt == 0) begin
                if (lsb0 || lsb1) begin
                    chk(lsb0 && lsb1, "R3", "bit-0 marker on both instances",
                        longint'({lsb0, lsb1}), 3);
                    cr0 = '0; ci0 = '0; cr1 = '0; ci1 = '0;
                    cr0[0] = mr0; ci0[0] = mi0; cr1[0] = mr1; ci1[0] = mi1;
                    extra_lsb = 1'b0;
                    mcnt = 1;
                end
            end else begin
                cr0[mcnt] = mr0; ci0[mcnt] = mi0; cr1[mcnt] = mr1; ci1[mcnt] = mi1;
                if (lsb0 || lsb1) extra_lsb = 1'b1;
                mcnt++;
                if (mcnt == W) begin
                    mcnt = 0;
                    if (q_tag.size() == 0) begin
                        chk(1'b0, "R7", "result frame with no word sent", 1, 0);
                    end else begin
                        string tg;
                        logic [W-1:0] er0, ei0, er1, ei1;
                        tg  = q_tag.pop_front();
                        er0 = q_r0.pop_front(); ei0 = q_i0.pop_front();
                        er1 = q_r1.pop_front(); ei1 = q_i1.pop_front();
                        chk(cr0 == er0, "R1", {"real part ", tg}, longint'(cr0), longint'(er0));
                        chk(ci0 == ei0, "R2", {"imag part ", tg}, longint'(ci0), longint'(ei0));
                        chk(cr1 == er1, "R8", {"real part u1 ", tg}, longint'(cr1), longint'(er1));
                        chk(ci1 == ei1, "R8", {"imag part u1 ", tg}, longint'(ci1), longint'(ei1));
                        chk(!extra_lsb, "R3", "marker only on bit 0", longint'(extra_lsb), 0);
                    end
                end
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R7: quiet outputs after reset, before any word.
        chk({lsb0, mr0, mi0, lsb1, mr1, mi1} == 6'd0, "R7", "outputs after reset",
            longint'({lsb0, mr0, mi0, lsb1, mr1, mi1}), 0);

        send(0, 0, 1'b0, "R6 zero");
        send(1, 0, 1'b0, "R1 unit real");
        send(0, 1, 1'b0, "R2 unit imag");
        send(-512, -512, 1'b0, "R5 min min");
        send(511, 511, 1'b0, "R5 max max");
        send(-512, 511, 1'b0, "R5 min max");
        send(511, -512, 1'b0, "R5 max min");
        send(-300, 177, 1'b0, "R4 quiet gap");
        send(-300, 177, 1'b1, "R4 random gap");
        for (int i = 0; i < 40; i++) begin
            send(int'($urandom_range(1023)) - 512, int'($urandom_range(1023)) - 512,
                 1'(i % 2), "R6 back to back");
        end

        // Idle with random operand bits and no word_start.
        for (int i = 0; i < 3 * W; i++) begin
            @(negedge clk);
            start = 1'b0;
            xr = 1'($urandom);
            xi = 1'($urandom);
        end
        chk(!lsb0 && !lsb1, "R7", "marker stays low while idle",
            longint'({lsb0, lsb1}), 0);
        chk(q_tag.size() == 0, "R3", "every word produced a result",
            longint'(q_tag.size()), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R3 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule